// File: doc/BRIEF.md
# Chromosome Recombination and Point-Mutation Unit

This block produces one offspring chromosome from two parent chromosomes in a single registered step. On an input strobe it samples both parents, a cut point, a bit-flip position, two 4-bit random draws and two 4-bit rate thresholds. The first stage is single-point recombination. When the recombination draw is below its threshold, the low bits of the offspring come from the first parent and the remaining bits come from the second. When the draw is not below the threshold, the first parent passes through unchanged.

The second stage can flip one bit of the first stage's result. This happens when a separate 4-bit draw is below the mutation threshold. The offspring is registered and appears together with an output strobe on the next clock cycle. A genetic search engine uses the unit between parent selection and fitness evaluation.

Top module: `xover_mut_unit`

## Requirements
- R1: After reset, `outValid` is 0 and `child` is 0.
- R2: `outValid` is 1 in exactly the cycle after each cycle in which `inValid` is 1, and 0 otherwise. `child` holds the offspring computed from the inputs sampled in that `inValid` cycle.
- R3: Recombination is taken when `xoverRand < xoverThresh` (unsigned, 4-bit). When it is taken, the intermediate result is `(parentA & mask) | (parentB & ~mask)`, where `mask` has ones at bit positions 0 to `cutPoint-1` and zeros at position `cutPoint` and above.
- R4: When recombination is not taken, the intermediate result equals `parentA`.
- R5: A `cutPoint` of 0 gives an all-zero mask, so the taken result equals `parentB`.
- R6: Mutation is taken when `mutRand < mutThresh` (unsigned, 4-bit). It inverts bit `mutPoint` of the intermediate result, so the offspring differs from it in exactly that one bit. Otherwise the offspring equals the intermediate result.
- R7: Mutation acts on the recombined result, not on `parentA`.
- R8: A threshold of 0 disables its operation. A threshold of 15 enables it for every draw except 15.
- R9: While `inValid` is 0, `child` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input sample strobe |
| parentA | input | 16 | First parent chromosome |
| parentB | input | 16 | Second parent chromosome |
| cutPoint | input | 4 | Recombination cut position |
| mutPoint | input | 4 | Bit index to flip |
| xoverRand | input | 4 | Recombination random draw |
| mutRand | input | 4 | Mutation random draw |
| xoverThresh | input | 4 | Recombination rate threshold |
| mutThresh | input | 4 | Mutation rate threshold |
| outValid | output | 1 | Offspring valid strobe |
| child | output | 16 | Offspring chromosome |

## Verification
Recombination and mutation can both act on the same sample. When they do, the flipped bit must be taken from the recombined word, not from the first parent. The bench forces this case by setting both thresholds to 15 and both draws below them. It sets the mutation point to a bit below the cut point where the two parents differ, and also to a bit above it. The bench predicts the offspring with a two-step reference function and compares it with the registered output one cycle after the strobe.

// File: rtl/xover_mut_pkg.sv
package xover_mut_pkg;
  parameter int unsigned GENE_W = 16;
  parameter int unsigned RATE_W = 4;
  localparam int unsigned IDX_W = $clog2(GENE_W);

  typedef struct packed {
    logic load;
    logic doXover;
    logic doMut;
  } ctrl_t;
endpackage

// File: rtl/xover_mut_ctrl.sv
module xover_mut_ctrl
  import xover_mut_pkg::*;
#(
  parameter int unsigned RW = RATE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [RW-1:0] xoverRand,
  input  logic [RW-1:0] mutRand,
  input  logic [RW-1:0] xoverThresh,
  input  logic [RW-1:0] mutThresh,
  output ctrl_t         ctrl,
  output logic          outValid
);
  always_comb begin
    ctrl.load    = inValid;
    ctrl.doXover = xoverRand < xoverThresh;
    ctrl.doMut   = mutRand < mutThresh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8
  zero_thresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xoverThresh == '0) |-> !ctrl.doXover);
  // R8
  max_thresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mutThresh == '1 && mutRand != '1) |-> ctrl.doMut);
  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
endmodule

// File: rtl/xover_mut_dp.sv
module xover_mut_dp
  import xover_mut_pkg::*;
#(
  parameter int unsigned GW = GENE_W,
  localparam int unsigned IW = $clog2(GW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [GW-1:0] parentA,
  input  logic [GW-1:0] parentB,
  input  logic [IW-1:0] cutPoint,
  input  logic [IW-1:0] mutPoint,
  output logic [GW-1:0] child
);
  logic [GW-1:0] cutMask, flipMask, mixed, mutated;

  for (genvar b = 0; b < GW; b++) begin : g_mask
    assign cutMask[b]  = (IW'(b) < cutPoint);
    assign flipMask[b] = (IW'(b) == mutPoint);
  end

  always_comb begin
    mixed   = ctrl.doXover ? ((parentA & cutMask) | (parentB & ~cutMask)) : parentA;
    mutated = ctrl.doMut ? (mixed ^ flipMask) : mixed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          child <= '0;
    else if (ctrl.load) child <= mutated;
  end

  // R6
  one_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mutated ^ mixed) == (ctrl.doMut ? 1 : 0));
  // R4
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.doXover |-> (mixed == parentA));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(child));
endmodule

// File: rtl/xover_mut_unit.sv
module xover_mut_unit
  import xover_mut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [GENE_W-1:0] parentA,
  input  logic [GENE_W-1:0] parentB,
  input  logic [IDX_W-1:0]  cutPoint,
  input  logic [IDX_W-1:0]  mutPoint,
  input  logic [RATE_W-1:0] xoverRand,
  input  logic [RATE_W-1:0] mutRand,
  input  logic [RATE_W-1:0] xoverThresh,
  input  logic [RATE_W-1:0] mutThresh,
  output logic              outValid,
  output logic [GENE_W-1:0] child
);
  ctrl_t ctrl;

  xover_mut_ctrl #(.RW(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .xoverRand(xoverRand), .mutRand(mutRand),
    .xoverThresh(xoverThresh), .mutThresh(mutThresh),
    .ctrl(ctrl), .outValid(outValid)
  );

  xover_mut_dp #(.GW(GENE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .parentA(parentA), .parentB(parentB),
    .cutPoint(cutPoint), .mutPoint(mutPoint),
    .child(child)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) $fell(rstN) |=> (!outValid && child == '0));
endmodule

// File: tb/test_xover_mut_unit.sv
module test_xover_mut_unit;
  logic clk = 0, rstN = 0, inValid = 0;
  logic [15:0] parentA = 0, parentB = 0;
  logic [3:0] cutPoint = 0, mutPoint = 0, xoverRand = 0, mutRand = 0, xoverThresh = 0, mutThresh = 0;
  logic outValid;
  logic [15:0] child;
  int total = 0, bad = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  xover_mut_unit i_xover_mut_unit (.*);

  function automatic logic [15:0] refChild(logic [15:0] a, logic [15:0] b, logic [3:0] cp,
      logic [3:0] mp, logic [3:0] xr, logic [3:0] mr, logic [3:0] xt, logic [3:0] mt);
    logic [15:0] m, r;
    m = 16'h0;
    for (int i = 0; i < 16; i++) if (i < cp) m[i] = 1'b1;
    r = (xr < xt) ? ((a & m) | (b & ~m)) : a;
    if (mr < mt) r[mp] = ~r[mp];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [15:0] a, logic [15:0] b, logic [3:0] cp, logic [3:0] mp,
      logic [3:0] xr, logic [3:0] mr, logic [3:0] xt, logic [3:0] mt);
    logic [15:0] exp;
    exp = refChild(a, b, cp, mp, xr, mr, xt, mt);
    @(negedge clk);
    parentA = a; parentB = b; cutPoint = cp; mutPoint = mp;
    xoverRand = xr; mutRand = mr; xoverThresh = xt; mutThresh = mt; inValid = 1;
    @(negedge clk);
    inValid = 0;
    check({req, " valid"}, {15'h0, outValid}, 16'h1);
    check(req, child, exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    #12 @(negedge clk);
    check("R1 valid", {15'h0, outValid}, 16'h0);
    check("R1 child", child, 16'h0);
    rstN = 1;
    // R3 taken, cut 8
    apply("R3", 16'hAAAA, 16'h5555, 4'd8, 4'd0, 4'd2, 4'd15, 4'd5, 4'd0);
    // R4 not taken (rand == thresh)
    apply("R4", 16'h1234, 16'hFFFF, 4'd8, 4'd0, 4'd5, 4'd15, 4'd5, 4'd0);
    // R5 cut zero
    apply("R5", 16'h1234, 16'hBEEF, 4'd0, 4'd0, 4'd0, 4'd15, 4'd9, 4'd0);
    // R6 mutation alone
    apply("R6", 16'h0000, 16'hFFFF, 4'd4, 4'd7, 4'd15, 4'd0, 4'd0, 4'd1);
    // R7 both, flip below cut where parents differ, and above cut
    apply("R7", 16'h00FF, 16'hFF00, 4'd8, 4'd3, 4'd1, 4'd3, 4'd15, 4'd15);
    apply("R7", 16'h00FF, 16'hFF00, 4'd4, 4'd12, 4'd1, 4'd3, 4'd15, 4'd15);
    // R8 threshold 0 and 15
    apply("R8 zero", 16'hC3C3, 16'h3C3C, 4'd6, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0);
    apply("R8 max", 16'hC3C3, 16'h3C3C, 4'd6, 4'd2, 4'd14, 4'd14, 4'd15, 4'd15);
    apply("R8 max15", 16'hC3C3, 16'h3C3C, 4'd6, 4'd2, 4'd15, 4'd15, 4'd15, 4'd15);
    // R9 hold while idle with changing inputs
    @(negedge clk);
    parentA = 16'hFFFF; parentB = 16'hFFFF; mutThresh = 4'd15; mutRand = 0;
    @(negedge clk);
    check("R9 hold", child, refChild(16'hC3C3, 16'h3C3C, 4'd6, 4'd2, 4'd15, 4'd15, 4'd15, 4'd15));
    check("R2 idle", {15'h0, outValid}, 16'h0);
    // R2 back-to-back random
    for (int k = 0; k < 200; k++) begin
      logic [15:0] a, b, exp;
      logic [3:0] cp, mp, xr, mr, xt, mt;
      a = 16'($urandom); b = 16'($urandom);
      cp = 4'($urandom); mp = 4'($urandom); xr = 4'($urandom);
      mr = 4'($urandom); xt = 4'($urandom); mt = 4'($urandom);
      exp = refChild(a, b, cp, mp, xr, mr, xt, mt);
      parentA = a; parentB = b; cutPoint = cp; mutPoint = mp;
      xoverRand = xr; mutRand = mr; xoverThresh = xt; mutThresh = mt; inValid = 1;
      @(negedge clk);
      check("R2 valid", {15'h0, outValid}, 16'h1);
      check("R2 child", child, exp);
    end
    inValid = 0;
    @(negedge clk);
    check("R2 drop", {15'h0, outValid}, 16'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule